// File: doc/BRIEF.md
# Shared Frame Buffer Fill and Host Release Controller

This block sits between a pixel producer and a single frame buffer that a host reads over a bridge. The producer offers one 16-bit word per cycle; while the buffer is open for filling the block accepts the word, generates its linear position from an internal word counter, and turns that position into a bank strobe and an in-bank address for one of three equal memory banks. The memories themselves live outside the block.

Once the last word of a frame has been stored, the block closes the buffer: it raises a level interrupt toward the host and refuses further producer writes. Only an acknowledge from the host, sent after it has read the frame out, reopens the buffer and rewinds the counter to the first word. A producer write that arrives while the buffer is closed is thrown away and leaves a sticky overrun flag that the host can clear.

Top module: `fbuf_handshake`

## Requirements
- R1: After a synchronous active-low reset, `host_irq_o` is 0, `wr_ready_o` is 1, `overrun_o` is 0 and no bank strobe is active.
- R2: While `wr_ready_o` is 1, each cycle with `wr_valid_i` high stores exactly one word in that same cycle: exactly one bit of `mem_we_o` is high and `mem_data_o` equals `wr_data_i`; consecutive accepted words take consecutive linear positions starting at 0.
- R3: A word at linear position p goes to bank p / BANK_WORDS (bit b of `mem_we_o` selects bank b) at in-bank address p mod BANK_WORDS, the low BANK_AW bits of p.
- R4: In the cycle after the FRAME_WORDS-th accepted write, `host_irq_o` is 1 and `wr_ready_o` is 0.
- R5: `host_irq_o` stays at 1 until a cycle with `host_ack_i` high; while it is 1 no bank strobe is ever active.
- R6: A write offered while `host_irq_o` is 1 raises no strobe, does not advance the position, and sets `overrun_o` from the next cycle on; the flag then stays set.
- R7: `overrun_clr_i` clears `overrun_o` in the next cycle, except when a refused write falls in the same cycle, in which case the flag stays 1.
- R8: `host_ack_i` while `host_irq_o` is 1 drops `host_irq_o` and raises `wr_ready_o` in the next cycle, and the following accepted write goes to bank 0, address 0.
- R9: `host_ack_i` while the buffer is filling has no effect: the next accepted write continues at the next linear position.
- R10: A write offered in the same cycle as the acknowledge that releases the buffer is refused and counts as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Producer offers a word this cycle |
| wr_data_i | input | DATA_W | Producer pixel word |
| host_ack_i | input | 1 | Host has finished reading the frame |
| overrun_clr_i | input | 1 | Host clears the overrun flag |
| wr_ready_o | output | 1 | Buffer is open for producer writes |
| mem_we_o | output | NUM_BANKS | Per-bank write strobe, bit b for bank b |
| mem_addr_o | output | BANK_AW | Address within the selected bank |
| mem_data_o | output | DATA_W | Data written to the selected bank |
| host_irq_o | output | 1 | Level frame-ready interrupt to the host |
| overrun_o | output | 1 | Sticky flag: a write was refused |

## Verification
Two pairs of events can coincide: the host's release acknowledge with a producer write, and the host's overrun clear with a refused write. The bench drives each pair in a single cycle while the buffer is closed and judges the outcome at the ports: no strobe may fire on the acknowledge cycle and the overrun flag must be set afterwards, and a clear that meets a refused write must leave the flag set. An acknowledge sent in mid-fill and the crossing of each bank boundary are also provoked, and a behavioural model of position, state and flag is compared with the outputs on every clock, while a bank memory model fed by the strobes is read back word by word after each frame.

// File: rtl/fbuf_pkg.sv
// Shared types for the frame buffer handshake controller.
package fbuf_pkg;

    // Buffer ownership: producer filling, or frame held for the host.
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_READY = 1'b1
    } fb_state_e;

endpackage

// File: rtl/fbuf_word_counter.sv
// Linear word position counter.
// Counts accepted producer writes from 0; flags the last word of a frame.
// Assumes the controller never increments past FRAME_WORDS; clear wins.
module fbuf_word_counter #(
    parameter int FRAME_WORDS = 76800,
    parameter int CW          = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);

    localparam logic [CW-1:0] LAST_POS = CW'(FRAME_WORDS - 1);

    logic [CW-1:0] count_q;

    // Advance on each accepted word, rewind on frame release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + CW'(1);
        end
    end

    // Current word closes the frame.
    always_comb begin
        last_o = (count_q == LAST_POS);
    end

    assign count_o = count_q;

endmodule

// File: rtl/fbuf_bank_decode.sv
// Bank decode for the frame buffer.
// Splits a linear word position into a one-hot bank strobe and an
// in-bank address. Assumes banks are 2**AW words deep, so the bank index
// is the position bits above AW.
module fbuf_bank_decode #(
    parameter int CW     = 17,
    parameter int AW     = 15,
    parameter int NB     = 3,
    parameter int DATA_W = 16
) (
    input  logic [CW-1:0]     pos_i,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [NB-1:0]     we_o,
    output logic [AW-1:0]     addr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int IW = CW - AW;

    logic [IW-1:0] bank_idx;

    assign bank_idx = pos_i[CW-1:AW];
    assign addr_o   = pos_i[AW-1:0];
    assign data_o   = data_i;

    // One comparator per bank drives that bank's strobe.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign we_o[b] = accept_i && (bank_idx == IW'(b));
    end

endmodule

// File: rtl/fbuf_ctrl_fsm.sv
// Ownership state machine for the frame buffer.
// FILL accepts producer words; the last word moves to READY, which holds
// the interrupt and refuses writes until the host acknowledges. Refused
// writes set a sticky overrun flag; set has priority over clear.
module fbuf_ctrl_fsm
    import fbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid_i,
    input  logic last_i,
    input  logic host_ack_i,
    input  logic overrun_clr_i,
    output logic accept_o,
    output logic cnt_clr_o,
    output logic host_irq_o,
    output logic wr_ready_o,
    output logic overrun_o
);

    fb_state_e state_q, state_d;
    logic      overrun_q;
    logic      refused;

    // Decode acceptance, refusal and release from the current state.
    always_comb begin
        accept_o  = (state_q == ST_FILL) && wr_valid_i;
        refused   = (state_q == ST_READY) && wr_valid_i;
        cnt_clr_o = (state_q == ST_READY) && host_ack_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (accept_o && last_i) state_d = ST_READY;
            ST_READY: if (host_ack_i)         state_d = ST_FILL;
            default:                          state_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky overrun flag, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (refused) begin
            overrun_q <= 1'b1;
        end else if (overrun_clr_i) begin
            overrun_q <= 1'b0;
        end
    end

    assign host_irq_o = (state_q == ST_READY);
    assign wr_ready_o = (state_q == ST_FILL);
    assign overrun_o  = overrun_q;

endmodule

// File: rtl/fbuf_handshake.sv
// Frame buffer fill and host release controller (top).
// Numbers producer words, spreads them over NUM_BANKS banks of 2**BANK_AW
// words, and runs the fill/ready/acknowledge protocol toward the host.
// Assumes FRAME_WORDS <= NUM_BANKS * 2**BANK_AW.
module fbuf_handshake #(
    parameter int DATA_W      = 16,
    parameter int BANK_AW     = 15,
    parameter int NUM_BANKS   = 3,
    parameter int FRAME_WORDS = 76800
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 host_ack_i,
    input  logic                 overrun_clr_i,
    output logic                 wr_ready_o,
    output logic [NUM_BANKS-1:0] mem_we_o,
    output logic [BANK_AW-1:0]   mem_addr_o,
    output logic [DATA_W-1:0]    mem_data_o,
    output logic                 host_irq_o,
    output logic                 overrun_o
);

    localparam int CW = $clog2(FRAME_WORDS + 1);

    logic [CW-1:0] pos;
    logic          last_word;
    logic          accept;
    logic          cnt_clr;

    fbuf_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid_i    (wr_valid_i),
        .last_i        (last_word),
        .host_ack_i    (host_ack_i),
        .overrun_clr_i (overrun_clr_i),
        .accept_o      (accept),
        .cnt_clr_o     (cnt_clr),
        .host_irq_o    (host_irq_o),
        .wr_ready_o    (wr_ready_o),
        .overrun_o     (overrun_o)
    );

    fbuf_word_counter #(
        .FRAME_WORDS (FRAME_WORDS),
        .CW          (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (accept),
        .clr_i   (cnt_clr),
        .count_o (pos),
        .last_o  (last_word)
    );

    fbuf_bank_decode #(
        .CW     (CW),
        .AW     (BANK_AW),
        .NB     (NUM_BANKS),
        .DATA_W (DATA_W)
    ) u_dec (
        .pos_i    (pos),
        .accept_i (accept),
        .data_i   (wr_data_i),
        .we_o     (mem_we_o),
        .addr_o   (mem_addr_o),
        .data_o   (mem_data_o)
    );

endmodule

// File: rtl/fbuf_handshake_chk.sv
// Protocol checker for fbuf_handshake, attached by bind below.
module fbuf_handshake_chk #(
    parameter int NUM_BANKS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid_i,
    input logic                 host_ack_i,
    input logic                 overrun_clr_i,
    input logic                 wr_ready_o,
    input logic [NUM_BANKS-1:0] mem_we_o,
    input logic                 host_irq_o,
    input logic                 overrun_o
);

    // R2: at most one bank strobed per cycle.
    a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_we_o));

    // R2: an offered word is stored while the buffer is open.
    a_r2_accept_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready_o && wr_valid_i) |-> (mem_we_o != '0));

    // R4: the interrupt only rises right after a stored word.
    a_r4_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq_o) |-> $past(mem_we_o != '0));

    // R5: no strobe while the frame is held for the host.
    a_r5_no_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> (mem_we_o == '0));

    // R5: interrupt holds until acknowledged.
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o && !host_ack_i) |=> host_irq_o);

    // R6: refused write sets the overrun flag.
    a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o && wr_valid_i) |=> overrun_o);

    // R7: flag is sticky without a clear.
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !overrun_clr_i) |=> overrun_o);

    // R8: acknowledge releases the buffer.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o && host_ack_i) |=> (!host_irq_o && wr_ready_o));

endmodule

bind fbuf_handshake fbuf_handshake_chk #(
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid_i    (wr_valid_i),
    .host_ack_i    (host_ack_i),
    .overrun_clr_i (overrun_clr_i),
    .wr_ready_o    (wr_ready_o),
    .mem_we_o      (mem_we_o),
    .host_irq_o    (host_irq_o),
    .overrun_o     (overrun_o)
);

// File: tb/fbuf_handshake_test.sv
// Bench: small frame (80 words over 3 banks of 32) for short runs.
module fbuf_handshake_test;

    localparam int PERIOD = 10;
    localparam int DW     = 16;
    localparam int AW     = 5;
    localparam int NB     = 3;
    localparam int FW     = 80;
    localparam int BW     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          host_ack = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          wr_ready;
    logic [NB-1:0] mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          host_irq;
    logic          overrun;

    int n_chk = 0;
    int n_err = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    fbuf_handshake #(
        .DATA_W (DW), .BANK_AW (AW), .NUM_BANKS (NB), .FRAME_WORDS (FW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .wr_valid_i (wr_valid), .wr_data_i (wr_data),
        .host_ack_i (host_ack), .overrun_clr_i (ovr_clr), .wr_ready_o (wr_ready),
        .mem_we_o (mem_we), .mem_addr_o (mem_addr), .mem_data_o (mem_data),
        .host_irq_o (host_irq), .overrun_o (overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int f, input int k);
        return DW'(f * 4096 + k * 5 + 1);
    endfunction

    // Behavioural bank memories fed by the strobes.
    logic [DW-1:0] bank_mem [NB][BW];
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (mem_we[b]) bank_mem[b][mem_addr] <= mem_data;
    end

    // Reference model: position, held flag, overrun flag.
    int m_cnt = 0;
    bit m_held = 1'b0;
    bit m_ovr = 1'b0;
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_held = 1'b0; m_ovr = 1'b0;
        end else begin
            if (m_held && wr_valid) m_ovr = 1'b1;
            else if (ovr_clr) m_ovr = 1'b0;
            if (!m_held && wr_valid) begin
                m_cnt++;
                if (m_cnt == FW) m_held = 1'b1;
            end else if (m_held && host_ack) begin
                m_held = 1'b0; m_cnt = 0;
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic acc;
            acc = !m_held && wr_valid;
            chk("R2/R3 strobe", 32'(mem_we), acc ? 32'(1 << (m_cnt / BW)) : 32'd0);
            if (acc) begin
                chk("R3 addr", 32'(mem_addr), 32'(m_cnt % BW));
                chk("R2 data", 32'(mem_data), 32'(wr_data));
            end
            chk("R4/R5 irq", 32'(host_irq), 32'(m_held));
            chk("R4 ready", 32'(wr_ready), 32'(!m_held));
            chk("R6/R7 overrun", 32'(overrun), 32'(m_ovr));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic put_word(input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_data = d;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic check_frame(input int f);
        for (int k = 0; k < FW; k++)
            chk("R3 bank contents", 32'(bank_mem[k / BW][k % BW]), 32'(pat(f, k)));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R1: reset state.
        chk("R1 irq", 32'(host_irq), 0);
        chk("R1 ready", 32'(wr_ready), 1);
        chk("R1 overrun", 32'(overrun), 0);
        chk("R1 strobe", 32'(mem_we), 0);
        rst_n = 1'b1;
        tick();

        // Frame 0, first half with idle gaps.
        for (int k = 0; k < 40; k++) begin
            put_word(pat(0, k));
            if (k % 7 == 6) tick();
        end
        // R9: acknowledge while filling is ignored.
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        wr_valid = 1'b1; wr_data = pat(0, 40);
        #2;
        chk("R9 strobe continues in bank 1", 32'(mem_we), 32'b010);
        chk("R9 address continues", 32'(mem_addr), 8);
        tick(); wr_valid = 1'b0;
        for (int k = 41; k < FW; k++) put_word(pat(0, k));
        // R4: frame complete.
        chk("R4 irq after last word", 32'(host_irq), 1);
        chk("R4 ready low", 32'(wr_ready), 0);
        repeat (3) tick();
        chk("R5 irq held", 32'(host_irq), 1);
        check_frame(0);

        // R6: refused write.
        wr_valid = 1'b1; wr_data = 16'hDEAD;
        #2;
        chk("R6 no strobe when held", 32'(mem_we), 0);
        tick(); wr_valid = 1'b0;
        chk("R6 overrun set", 32'(overrun), 1);
        repeat (2) tick();
        chk("R6 overrun sticky", 32'(overrun), 1);
        // R7: clear meets refused write, set wins.
        ovr_clr = 1'b1; wr_valid = 1'b1;
        tick(); wr_valid = 1'b0;
        chk("R7 set beats clear", 32'(overrun), 1);
        tick(); ovr_clr = 1'b0;
        chk("R7 clear", 32'(overrun), 0);
        check_frame(0);

        // R10: write in the release cycle is refused.
        host_ack = 1'b1; wr_valid = 1'b1; wr_data = 16'hBEEF;
        #2;
        chk("R10 no strobe on release", 32'(mem_we), 0);
        tick(); host_ack = 1'b0; wr_valid = 1'b0;
        chk("R10 overrun", 32'(overrun), 1);
        chk("R8 irq dropped", 32'(host_irq), 0);
        chk("R8 ready", 32'(wr_ready), 1);
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;

        // R8: next frame starts at bank 0, address 0.
        wr_valid = 1'b1; wr_data = pat(1, 0);
        #2;
        chk("R8 restart bank 0", 32'(mem_we), 32'b001);
        chk("R8 restart address 0", 32'(mem_addr), 0);
        tick(); wr_valid = 1'b0;
        for (int k = 1; k < FW; k++) put_word(pat(1, k));
        chk("R4 irq second frame", 32'(host_irq), 1);
        check_frame(1);
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        chk("R8 second release", 32'(host_irq), 0);
        repeat (2) tick();
        finish_run();
    end

endmodule